// File: doc/BRIEF.md
# Page-Hit-Aware Flash Read Sequencer

This block sits on the host side of an asynchronous NOR flash that offers a fast in-page read. A client presents a byte address and a byte/word flag on a req/ack interface. The block drives the flash address lines, the lowest byte-select line, the bus-width pin and the active-low chip-select and output-enable strobes. It then counts a number of system clocks before it registers the flash data and returns it with a one-cycle ack.

A page is eight bytes. In word mode that is four 16-bit words, and in byte mode it is eight bytes. The block keeps the page bits and the bus mode of the last access it started. A read whose page bits and mode both match uses the short in-page wait count. Any other read uses the full random-access wait count. The stored page is forgotten on reset and after a write-cycle notice from elsewhere on the shared bus. If the client issues a new request in the ack cycle, the strobes stay low across the boundary. Otherwise the strobes rise and the flash outputs are released.

Top module: `flash_page_reader`

## Requirements
- R1: During and right after reset, `fl_ce_n` and `fl_oe_n` are 1, `ack` is 0, and no page is remembered, so the first read is a miss.
- R2: The first read after reset asserts `ack` exactly `random_wait` clocks after the clock edge that accepts the request.
- R3: A read whose page tag `req_addr[BYTE_ADDR_W-1:3]` and `req_byte` both equal those of the previously started read asserts `ack` `page_wait` clocks after acceptance. This holds both back to back and after an idle gap.
- R4: A read whose page tag differs from the previous one uses `random_wait`.
- R5: A read whose `req_byte` differs from the previous one uses `random_wait`, even when the page tag is the same.
- R6: A one-cycle `bus_write` pulse makes the next started read use `random_wait`.
- R7: While `fl_oe_n` is 0, three outputs follow the request. `fl_addr` equals `req_addr[BYTE_ADDR_W-1:1]`. `fl_byte_n` is 0 in byte mode and 1 in word mode. `fl_lsb` equals `req_addr[0]` in byte mode and 0 in word mode. Within one access these outputs hold steady.
- R8: `ack` is high for one cycle per read. In that cycle `rsp_data` holds `fl_dq` as it was at the capture edge. In word mode that is the full word. In byte mode it is `fl_dq[7:0]` with the upper bits 0.
- R9: `fl_ce_n` and `fl_oe_n` go low at acceptance and stay low through the ack cycle. A request present in the ack cycle keeps them low. Otherwise they rise after the ack cycle.
- R10: A wait count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request, held until ack |
| req_addr | input | BYTE_ADDR_W | Byte address; bit 0 is the byte select |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| random_wait | input | CNT_W | Clocks for a page-miss read |
| page_wait | input | CNT_W | Clocks for a page-hit read (not above random_wait) |
| bus_write | input | 1 | Notice that a flash write cycle took place |
| ack | output | 1 | Read complete, data valid this cycle |
| rsp_data | output | DATA_W | Read data |
| fl_addr | output | BYTE_ADDR_W-1 | Flash word address lines |
| fl_lsb | output | 1 | Flash byte-select address line |
| fl_byte_n | output | 1 | Flash bus-width select, 0 = byte |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_dq | input | DATA_W | Flash data lines |

## Verification
The hardest cases to reach are those where the page tag still matches but the hit must be refused. One is a mode switch onto the same page. The other is a write notice that arrives while the block is idle between two reads of one page. The stimulus reaches both by reading a page in word mode, then rereading the same eight bytes in byte mode. It then pulses `bus_write` in an idle gap and reads that page again. A behavioural model predicts the hit or miss and the exact ack cycle of every read. The stimulus also mixes back-to-back and gapped requests, so both strobe behaviours around the ack cycle are covered.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } rd_state_t;

  // Bytes per page are fixed at eight; the tag starts above this bit count.
  localparam int unsigned PAGE_OFS_W = 3;
  localparam int unsigned LANE_W     = 8;

endpackage

// File: rtl/page_tag_tracker.sv
module page_tag_tracker #(
  parameter int unsigned TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             look_byte,
  input  logic             store,
  input  logic             forget,
  output logic             hit
);

  logic [TAG_W-1:0] tag_q;
  logic             byte_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q   <= '0;
      byte_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (store) begin
        tag_q   <= look_tag;
        byte_q  <= look_byte;
        valid_q <= 1'b1;
      end
      if (forget) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign hit = valid_q && (tag_q == look_tag) && (byte_q == look_byte);

endmodule

// File: rtl/wait_counter.sv
module wait_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cycles,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] start_val;

  // A request of N clocks leaves N-1 decrements after the load edge; 0 acts as 1.
  assign start_val = (load_cycles == '0) ? '0 : load_cycles - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= start_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader
  import flash_rd_pkg::*;
#(
  parameter int unsigned BYTE_ADDR_W = 24,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req,
  input  logic [BYTE_ADDR_W-1:0] req_addr,
  input  logic                   req_byte,
  input  logic [CNT_W-1:0]       random_wait,
  input  logic [CNT_W-1:0]       page_wait,
  input  logic                   bus_write,
  output logic                   ack,
  output logic [DATA_W-1:0]      rsp_data,
  output logic [BYTE_ADDR_W-2:0] fl_addr,
  output logic                   fl_lsb,
  output logic                   fl_byte_n,
  output logic                   fl_ce_n,
  output logic                   fl_oe_n,
  input  logic [DATA_W-1:0]      fl_dq
);

  localparam int unsigned TAG_W = BYTE_ADDR_W - PAGE_OFS_W;

  rd_state_t        state_q;
  logic             accept;
  logic             page_hit;
  logic             wait_done;
  logic [CNT_W-1:0] cycles_sel;
  logic             byte_q;
  logic [DATA_W-1:0] lane_data;

  assign accept     = req && (state_q == ST_IDLE || state_q == ST_ACK);
  assign cycles_sel = page_hit ? page_wait : random_wait;

  page_tag_tracker #(.TAG_W(TAG_W)) i_tags (
    .clk       (clk),
    .rst       (rst),
    .look_tag  (req_addr[BYTE_ADDR_W-1:PAGE_OFS_W]),
    .look_byte (req_byte),
    .store     (accept),
    .forget    (bus_write),
    .hit       (page_hit)
  );

  wait_counter #(.CNT_W(CNT_W)) i_wait (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .load_cycles (cycles_sel),
    .expired     (wait_done)
  );

  generate
    if (DATA_W > LANE_W) begin : g_wide
      assign lane_data = byte_q ? {{(DATA_W-LANE_W){1'b0}}, fl_dq[LANE_W-1:0]} : fl_dq;
    end else begin : g_narrow
      assign lane_data = fl_dq;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ack       <= 1'b0;
      rsp_data  <= '0;
      fl_addr   <= '0;
      fl_lsb    <= 1'b0;
      fl_byte_n <= 1'b1;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      byte_q    <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (accept) begin
        state_q   <= ST_WAIT;
        fl_addr   <= req_addr[BYTE_ADDR_W-1:1];
        fl_lsb    <= req_byte & req_addr[0];
        fl_byte_n <= ~req_byte;
        byte_q    <= req_byte;
        fl_ce_n   <= 1'b0;
        fl_oe_n   <= 1'b0;
      end else begin
        case (state_q)
          ST_WAIT: begin
            if (wait_done) begin
              rsp_data <= lane_data;
              ack      <= 1'b1;
              state_q  <= ST_ACK;
            end
          end
          ST_ACK: begin
            state_q <= ST_IDLE;
            fl_ce_n <= 1'b1;
            fl_oe_n <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_page_reader_chk.sv
module flash_page_reader_chk #(
  parameter int unsigned BYTE_ADDR_W = 24
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ack,
  input logic [BYTE_ADDR_W-2:0] fl_addr,
  input logic                   fl_lsb,
  input logic                   fl_byte_n,
  input logic                   fl_ce_n,
  input logic                   fl_oe_n
);

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: the edge after a reset cycle leaves the strobes idle
  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      p_reset_idle_r1: assert (fl_ce_n && fl_oe_n && !ack);
    end
  end

  p_ack_selected_r8: assert property (@(posedge clk) disable iff (rst)
    ack |-> (!fl_oe_n && !fl_ce_n));

  p_ce_with_oe_r9: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_ce_n);

  p_oe_release_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_oe_n) |-> $past(ack));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!fl_oe_n && $past(!fl_oe_n && !ack)) |-> ($stable(fl_addr) && $stable(fl_lsb) && $stable(fl_byte_n)));

  p_lsb_word_r7: assert property (@(posedge clk) disable iff (rst)
    fl_byte_n |-> !fl_lsb);

endmodule

bind flash_page_reader flash_page_reader_chk #(.BYTE_ADDR_W(BYTE_ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .fl_addr   (fl_addr),
  .fl_lsb    (fl_lsb),
  .fl_byte_n (fl_byte_n),
  .fl_ce_n   (fl_ce_n),
  .fl_oe_n   (fl_oe_n)
);

// File: tb/test_flash_page_reader.sv
module test_flash_page_reader;
  localparam int PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_byte = 1'b0;
  logic [CW-1:0] random_wait = 8'd6;
  logic [CW-1:0] page_wait = 8'd2;
  logic bus_write = 1'b0;
  logic ack;
  logic [DW-1:0] rsp_data;
  logic [AW-2:0] fl_addr;
  logic fl_lsb, fl_byte_n, fl_ce_n, fl_oe_n;
  logic [DW-1:0] fl_dq;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  flash_page_reader #(.BYTE_ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_flash_page_reader (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_byte(req_byte),
    .random_wait(random_wait), .page_wait(page_wait), .bus_write(bus_write),
    .ack(ack), .rsp_data(rsp_data), .fl_addr(fl_addr), .fl_lsb(fl_lsb),
    .fl_byte_n(fl_byte_n), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_dq(fl_dq)
  );

  // Flash content model: word at a word address, byte selected by the lsb line.
  function automatic logic [15:0] word_at(input logic [AW-2:0] wa);
    return {wa[7:0] ^ 8'h5A, wa[15:8] + wa[3:0] + 8'h33};
  endfunction

  always_comb begin
    if (fl_oe_n) fl_dq = 16'hDEAD;
    else if (!fl_byte_n) fl_dq = {8'hA5, fl_lsb ? word_at(fl_addr)[15:8] : word_at(fl_addr)[7:0]};
    else fl_dq = word_at(fl_addr);
  end

  task automatic check(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: one access at a time, updated at each rising edge.
  bit m_busy, m_ack, m_oe_n, m_valid, m_mode, m_byte;
  int m_rem;
  logic [AW-4:0] m_tag;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  string m_why, m_cur;

  always @(posedge clk) begin
    bit st, hit;
    int w;
    if (rst) begin
      m_busy = 0; m_ack = 0; m_oe_n = 1; m_valid = 0; m_why = "R2"; m_cur = "R1";
    end else begin
      st = 0;
      if (m_ack) begin
        m_ack = 0;
        if (req) st = 1; else m_oe_n = 1;
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; m_ack = 1;
          if (m_byte) m_data = {8'h00, m_addr[0] ? word_at(m_addr[AW-1:1])[15:8] : word_at(m_addr[AW-1:1])[7:0]};
          else m_data = word_at(m_addr[AW-1:1]);
        end
      end else if (req) st = 1;
      if (st) begin
        hit = m_valid && m_tag == req_addr[AW-1:3] && m_mode == req_byte;
        if (!m_valid) m_cur = m_why;
        else if (m_mode != req_byte) m_cur = "R5";
        else if (!hit) m_cur = "R4";
        else m_cur = "R3";
        w = hit ? int'(page_wait) : int'(random_wait);
        if (w == 0) begin w = 1; m_cur = {m_cur, "/R10"}; end
        m_rem = w; m_busy = 1; m_oe_n = 0;
        m_addr = req_addr; m_byte = req_byte;
        m_tag = req_addr[AW-1:3]; m_mode = req_byte; m_valid = 1;
      end
      if (bus_write) begin m_valid = 0; m_why = "R6"; end
    end
  end

  // Cycle compare, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      check(ack == m_ack, m_cur, "ack", ack, m_ack);
      check(fl_oe_n == m_oe_n, "R9", "oe_n", fl_oe_n, m_oe_n);
      check(fl_ce_n == m_oe_n, "R9", "ce_n", fl_ce_n, m_oe_n);
      if (m_ack) check(rsp_data == m_data, "R8", "rsp_data", rsp_data, m_data);
      if (!m_oe_n) begin
        check(fl_addr == m_addr[AW-1:1], "R7", "fl_addr", fl_addr, m_addr[AW-1:1]);
        check(fl_byte_n == !m_byte, "R7", "fl_byte_n", fl_byte_n, !m_byte);
        check(fl_lsb == (m_byte & m_addr[0]), "R7", "fl_lsb", fl_lsb, m_byte & m_addr[0]);
      end
    end
  end

  // Issue one read starting at a falling edge; returns at the falling edge inside the ack cycle.
  task automatic rd(input logic [AW-1:0] a, input bit bm, input int exp_w, input string rq);
    int n = 0;
    req = 1; req_addr = a; req_byte = bm;
    do begin
      @(negedge clk);
      n++;
    end while (!ack && n < 200);
    check(n - 1 == exp_w, rq, "latency", n - 1, exp_w);
  endtask

  task automatic idle(input int c);
    req = 0;
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(fl_ce_n && fl_oe_n && !ack, "R1", "reset strobes", {fl_ce_n, fl_oe_n, ack}, 3'b110);
    @(negedge clk);
    rst = 0;
    check(fl_ce_n && fl_oe_n && !ack, "R1", "after reset", {fl_ce_n, fl_oe_n, ack}, 3'b110);
    rd(24'h001230, 0, 6, "R2");
    rd(24'h001232, 0, 2, "R3");
    rd(24'h001236, 0, 2, "R3");
    idle(3);
    rd(24'h001234, 0, 2, "R3");
    rd(24'h001238, 0, 6, "R4");
    idle(2);
    rd(24'h001239, 1, 6, "R5");
    rd(24'h00123F, 1, 2, "R3");
    rd(24'h00123A, 1, 2, "R3");
    idle(1);
    bus_write = 1; @(negedge clk); bus_write = 0;
    idle(1);
    rd(24'h00123B, 1, 6, "R6");
    rd(24'h00123C, 0, 6, "R5");
    rd(24'hABCDE0, 0, 6, "R4");
    idle(2);
    page_wait = 0;
    rd(24'hABCDE4, 0, 1, "R10");
    rd(24'hABCDE6, 0, 1, "R10");
    random_wait = 0;
    rd(24'h000100, 0, 1, "R10");
    idle(3);
    check(fl_oe_n && fl_ce_n, "R9", "idle release", {fl_oe_n, fl_ce_n}, 2'b11);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule